// File: doc/BRIEF.md
# Vector Compare-to-Mask Unit

This block takes two integer vectors and produces a packed bit mask, one bit per element, instead of a vector result. In compare mode a 3-bit predicate code chooses which relation is tested between the element pairs. The comparison is signed or unsigned, as a separate input selects. In the two test modes the unit ANDs each element pair. It then sets the bit when that AND is non-zero, or in the inverted mode when it is zero.

Elements are 8, 16, 32 or 64 bits wide within a fixed vector width. A governing mask can clear individual result bits. It is taken from a bank of eight mask values supplied by the surrounding register file. Selector 0 means unmasked. The result is captured in an output register one cycle after a valid input, and it keeps its value until the next valid input.

Top module: `vmask_cmp`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and mask_o is all zeros.
- R2: valid_o equals valid_i of the previous cycle. mask_o loads the result computed from the inputs of a cycle with valid_i high, and holds its value in every cycle with valid_i low.
- R3: esize_i selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element j occupies bits [j*EW +: EW] of a_i and b_i and drives mask bit j. Mask bits at and above VEC_W/EW are 0.
- R4: With op_i=0 (compare), pred_i selects the relation a versus b: 0 is EQ, 1 is LT, 2 is LE, 3 is FALSE, 4 is NE, 5 is GE, 6 is GT and 7 is TRUE.
- R5: With signed_i=1, the LT, LE, GE and GT relations treat elements as two's complement. With signed_i=0 they treat elements as unsigned.
- R6: op_i=1 sets bit j when (a_j AND b_j) is non-zero. op_i=2 sets bit j when (a_j AND b_j) is zero. op_i=3 produces an all-zero mask.
- R7: gsel_i=0 enables every element, and the contents of kfile_i slice 0 have no effect. gsel_i=g in 1..7 uses kfile_i[g*MASK_W +: MASK_W] as the governing mask. Any result bit whose governing bit is 0 is written as 0.
- R8: Predicate FALSE yields an all-zero mask. Predicate TRUE sets exactly the active element bits that the governing mask enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request this cycle |
| op_i | input | 2 | 0 compare, 1 test non-zero, 2 test zero, 3 reserved |
| pred_i | input | 3 | Compare predicate code |
| signed_i | input | 1 | Signed compare when 1 |
| esize_i | input | 2 | Element width select |
| gsel_i | input | 3 | Governing mask selector, 0 means unmasked |
| kfile_i | input | 8*MASK_W | Eight mask values, slice g at [g*MASK_W +: MASK_W] |
| a_i | input | VEC_W | First source vector |
| b_i | input | VEC_W | Second source vector |
| valid_o | output | 1 | Result register holds a new result |
| mask_o | output | MASK_W | Packed result mask (MASK_W = VEC_W/8) |

## Verification
Governing masking and active-width truncation act on the same result bits in the same cycle. The bench provokes this with wide-element operations under governing masks that have bits set above the active element count, such as predicate TRUE on 64-bit elements with an all-ones governing mask. Any stray upper bit shows up as a mismatch against a reference computed in the bench. Back-to-back valid cycles with different modes also make the register load and the mode switch coincide. Each cycle's mask is then judged separately.

// File: rtl/vmask_cmp_pkg.sv
package vmask_cmp_pkg;

  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_TNZ  = 2'd1,
    OP_TZ   = 2'd2,
    OP_RSV  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PR_EQ = 3'd0,
    PR_LT = 3'd1,
    PR_LE = 3'd2,
    PR_F  = 3'd3,
    PR_NE = 3'd4,
    PR_GE = 3'd5,
    PR_GT = 3'd6,
    PR_T  = 3'd7
  } pred_e;

  localparam int unsigned NUM_ESIZE = 4;

  function automatic logic pred_eval(input pred_e pr, input logic eq, input logic lt);
    logic r;
    unique case (pr)
      PR_EQ:   r = eq;
      PR_LT:   r = lt;
      PR_LE:   r = lt | eq;
      PR_F:    r = 1'b0;
      PR_NE:   r = ~eq;
      PR_GE:   r = ~lt;
      PR_GT:   r = ~(lt | eq);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vmask_elem.sv
module vmask_elem
  import vmask_cmp_pkg::*;
#(
  parameter int unsigned EW = 8
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic          signed_i,
  input  logic [1:0]    op_i,
  input  logic [2:0]    pred_i,
  output logic          bit_o
);

  logic signed [EW:0] a_ext;
  logic signed [EW:0] b_ext;
  logic               eq;
  logic               lt;
  logic               and_nz;

  // one extra bit lets a single signed comparator serve both signednesses
  assign a_ext  = {signed_i & a_i[EW-1], a_i};
  assign b_ext  = {signed_i & b_i[EW-1], b_i};
  assign eq     = (a_i == b_i);
  assign lt     = (a_ext < b_ext);
  assign and_nz = |(a_i & b_i);

  always_comb begin
    unique case (op_e'(op_i))
      OP_CMP:  bit_o = pred_eval(pred_e'(pred_i), eq, lt);
      OP_TNZ:  bit_o = and_nz;
      OP_TZ:   bit_o = ~and_nz;
      default: bit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vmask_lanes.sv
module vmask_lanes #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned EW     = 8,
  parameter int unsigned MASK_W = VEC_W / 8
) (
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  input  logic              signed_i,
  input  logic [1:0]        op_i,
  input  logic [2:0]        pred_i,
  output logic [MASK_W-1:0] res_o
);

  localparam int unsigned NLANE = VEC_W / EW;

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    vmask_elem #(.EW(EW)) u_elem (
      .a_i      (a_i[j*EW +: EW]),
      .b_i      (b_i[j*EW +: EW]),
      .signed_i (signed_i),
      .op_i     (op_i),
      .pred_i   (pred_i),
      .bit_o    (res_o[j])
    );
  end

  if (NLANE < MASK_W) begin : g_pad
    assign res_o[MASK_W-1:NLANE] = '0;
  end

endmodule

// File: rtl/vmask_gov.sv
module vmask_gov #(
  parameter int unsigned MASK_W = 16,
  parameter int unsigned NUM_K  = 8,
  localparam int unsigned SEL_W = $clog2(NUM_K)
) (
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [NUM_K*MASK_W-1:0] kfile_i,
  output logic [MASK_W-1:0]       gov_o
);

  logic [MASK_W-1:0] kreg [NUM_K];

  for (genvar g = 0; g < NUM_K; g++) begin : g_slice
    assign kreg[g] = kfile_i[g*MASK_W +: MASK_W];
  end

  // selector 0 is hardwired to "all enabled"; slice 0 is never read here
  always_comb begin
    gov_o = '1;
    for (int g = 1; g < NUM_K; g++) begin
      if (sel_i == SEL_W'(g)) gov_o = kreg[g];
    end
  end

endmodule

// File: rtl/vmask_cmp.sv
module vmask_cmp
  import vmask_cmp_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned NUM_K = 8,
  localparam int unsigned MASK_W = VEC_W / 8,
  localparam int unsigned SEL_W  = $clog2(NUM_K)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              op_i,
  input  logic [2:0]              pred_i,
  input  logic                    signed_i,
  input  logic [1:0]              esize_i,
  input  logic [SEL_W-1:0]        gsel_i,
  input  logic [NUM_K*MASK_W-1:0] kfile_i,
  input  logic [VEC_W-1:0]        a_i,
  input  logic [VEC_W-1:0]        b_i,
  output logic                    valid_o,
  output logic [MASK_W-1:0]       mask_o
);

  logic [MASK_W-1:0] res_w [NUM_ESIZE];
  logic [MASK_W-1:0] res_sel;
  logic [MASK_W-1:0] gov;
  logic [MASK_W-1:0] res_d;
  logic [MASK_W-1:0] mask_q;
  logic              valid_q;

  for (genvar s = 0; s < NUM_ESIZE; s++) begin : g_width
    vmask_lanes #(
      .VEC_W  (VEC_W),
      .EW     (8 << s),
      .MASK_W (MASK_W)
    ) u_lanes (
      .a_i      (a_i),
      .b_i      (b_i),
      .signed_i (signed_i),
      .op_i     (op_i),
      .pred_i   (pred_i),
      .res_o    (res_w[s])
    );
  end

  assign res_sel = res_w[esize_i];

  vmask_gov #(
    .MASK_W (MASK_W),
    .NUM_K  (NUM_K)
  ) u_gov (
    .sel_i   (gsel_i),
    .kfile_i (kfile_i),
    .gov_o   (gov)
  );

  assign res_d = res_sel & gov;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) mask_q <= res_d;
    end
  end

  assign valid_o = valid_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/vmask_cmp_chk.sv
module vmask_cmp_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned NUM_K = 8,
  localparam int unsigned MASK_W = VEC_W / 8,
  localparam int unsigned SEL_W  = $clog2(NUM_K)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [1:0]              op_i,
  input logic [2:0]              pred_i,
  input logic [1:0]              esize_i,
  input logic [SEL_W-1:0]        gsel_i,
  input logic [NUM_K*MASK_W-1:0] kfile_i,
  input logic                    valid_o,
  input logic [MASK_W-1:0]       mask_o
);

  logic [MASK_W-1:0] act;
  logic [MASK_W-1:0] gsl;

  assign act = {MASK_W{1'b1}} >> (MASK_W - (MASK_W >> esize_i));
  assign gsl = kfile_i[gsel_i*MASK_W +: MASK_W];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (!valid_o && mask_o == '0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mask_o));

  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (mask_o & ~$past(act)) == '0);

  a_r6_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |=> mask_o == '0);

  a_r7_governed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gsel_i != '0) |=> (mask_o & ~$past(gsl)) == '0);

  a_r8_false_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && pred_i == 3'd3) |=> mask_o == '0);

endmodule

bind vmask_cmp vmask_cmp_chk #(.VEC_W(VEC_W), .NUM_K(NUM_K)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .pred_i  (pred_i),
  .esize_i (esize_i),
  .gsel_i  (gsel_i),
  .kfile_i (kfile_i),
  .valid_o (valid_o),
  .mask_o  (mask_o)
);

// File: tb/vmask_cmp_tb.sv
`timescale 1ns/1ps
module vmask_cmp_tb;

  localparam int unsigned VW = 128;
  localparam int unsigned MW = VW / 8;
  localparam int unsigned NK = 8;

  typedef struct packed {
    logic [1:0]    op;
    logic [2:0]    pr;
    logic          sg;
    logic [1:0]    es;
    logic [2:0]    gs;
    logic [VW-1:0] a;
    logic [VW-1:0] b;
  } vec_t;

  localparam logic [VW-1:0] A1 = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
  localparam logic [VW-1:0] B1 = 128'h0011_2234_4455_6676_8899_AABA_CCDE_EEFF;
  localparam logic [VW-1:0] A2 = 128'h8000_0000_7FFF_FFFF_FFFF_FFFF_0000_0001;
  localparam logic [VW-1:0] B2 = 128'h7FFF_FFFF_8000_0000_0000_0000_FFFF_FFFF;
  localparam logic [VW-1:0] A3 = 128'hF0F0_F0F0_0F0F_0F0F_FF00_FF00_00FF_00FF;
  localparam logic [VW-1:0] B3 = 128'h0F0F_0F0F_0F0F_0F0F_00FF_00FF_00FF_00FF;

  localparam int NT = 18;
  localparam vec_t TBL [NT] = '{
    '{2'd0, 3'd0, 1'b0, 2'd0, 3'd0, A1, B1},
    '{2'd0, 3'd1, 1'b0, 2'd0, 3'd0, A1, B1},
    '{2'd0, 3'd2, 1'b0, 2'd1, 3'd0, A1, B1},
    '{2'd0, 3'd4, 1'b0, 2'd1, 3'd0, A1, B1},
    '{2'd0, 3'd5, 1'b0, 2'd2, 3'd0, A2, B2},
    '{2'd0, 3'd6, 1'b0, 2'd2, 3'd0, A2, B2},
    '{2'd0, 3'd1, 1'b1, 2'd2, 3'd0, A2, B2},
    '{2'd0, 3'd6, 1'b1, 2'd0, 3'd0, A2, B2},
    '{2'd0, 3'd2, 1'b1, 2'd1, 3'd0, A2, B2},
    '{2'd0, 3'd5, 1'b1, 2'd3, 3'd0, A2, B2},
    '{2'd0, 3'd3, 1'b0, 2'd0, 3'd0, A1, A1},
    '{2'd0, 3'd7, 1'b0, 2'd3, 3'd5, A1, B1},
    '{2'd1, 3'd0, 1'b0, 2'd0, 3'd0, A3, B3},
    '{2'd2, 3'd0, 1'b0, 2'd1, 3'd0, A3, B3},
    '{2'd1, 3'd0, 1'b0, 2'd2, 3'd3, A3, B3},
    '{2'd3, 3'd7, 1'b0, 2'd0, 3'd0, A1, B1},
    '{2'd0, 3'd0, 1'b0, 2'd0, 3'd1, A1, B1},
    '{2'd0, 3'd4, 1'b1, 2'd1, 3'd7, A2, B2}
  };

  logic [MW-1:0] kv [NK];

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [1:0]        op_i = '0;
  logic [2:0]        pred_i = '0;
  logic              signed_i = 1'b0;
  logic [1:0]        esize_i = '0;
  logic [2:0]        gsel_i = '0;
  logic [NK*MW-1:0]  kfile_i;
  logic [VW-1:0]     a_i = '0;
  logic [VW-1:0]     b_i = '0;
  logic              valid_o;
  logic [MW-1:0]     mask_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  initial begin
    kv[0] = 16'h0000; kv[1] = 16'hAAAA; kv[2] = 16'h00FF; kv[3] = 16'hF0F0;
    kv[4] = 16'h0001; kv[5] = 16'hFFFF; kv[6] = 16'h8000; kv[7] = 16'h1234;
  end
  always_comb for (int g = 0; g < NK; g++) kfile_i[g*MW +: MW] = kv[g];

  vmask_cmp #(.VEC_W(VW), .NUM_K(NK)) u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .pred_i, .signed_i, .esize_i,
    .gsel_i, .kfile_i, .a_i, .b_i, .valid_o, .mask_o
  );

  function automatic logic [MW-1:0] model(input vec_t v);
    int ew;
    int n;
    logic [63:0] ea, eb, msk, tb;
    logic lt, eq, r;
    logic [MW-1:0] res;
    ew  = 8 << v.es;
    n   = VW / ew;
    msk = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    tb  = 64'd1 << (ew - 1);
    res = '0;
    for (int j = 0; j < n; j++) begin
      ea = 64'(v.a >> (j * ew)) & msk;
      eb = 64'(v.b >> (j * ew)) & msk;
      if (v.sg) begin ea = ea ^ tb; eb = eb ^ tb; end
      lt = ea < eb;
      eq = ea == eb;
      case (v.op)
        2'd0: case (v.pr)
                3'd0: r = eq;       3'd1: r = lt;
                3'd2: r = lt || eq; 3'd3: r = 1'b0;
                3'd4: r = !eq;      3'd5: r = !lt;
                3'd6: r = !lt && !eq;
                default: r = 1'b1;
              endcase
        2'd1: r = |(ea & eb);
        2'd2: r = ~|(ea & eb);
        default: r = 1'b0;
      endcase
      res[j] = r;
    end
    if (v.gs != 0) res = res & kv[v.gs];
    return res;
  endfunction

  task automatic check(input string tag, input logic [MW-1:0] got, input logic [MW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_i = v.op; pred_i = v.pr; signed_i = v.sg; esize_i = v.es;
    gsel_i = v.gs; a_i = v.a; b_i = v.b;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.op != 0) return "R6";
    if (v.gs != 0) return "R7";
    if (v.pr == 3'd3 || v.pr == 3'd7) return "R8";
    if (v.sg) return "R5";
    if (v.es != 0) return "R3";
    return "R4";
  endfunction

  task automatic run_one(input vec_t v);
    @(negedge clk_i);
    drive(v);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 valid_o", MW'(valid_o), MW'(1));
    check(tag_of(v), mask_o, model(v));
  endtask

  initial begin
    vec_t v;
    vec_t w;
    logic [MW-1:0] held;
    #1;
    // R1: state during reset
    check("R1 valid_o", MW'(valid_o), '0);
    check("R1 mask_o", mask_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NT; i++) run_one(TBL[i]);

    // R5: hand values, 64-bit elements, low elem all ones vs 0, high 1 vs 2
    v = '{2'd0, 3'd1, 1'b0, 2'd3, 3'd0,
          {64'd1, 64'hFFFF_FFFF_FFFF_FFFF}, {64'd2, 64'd0}};
    run_one(v);
    check("R5 unsigned LT", mask_o, 16'h0002);
    v.sg = 1'b1;
    run_one(v);
    check("R5 signed LT", mask_o, 16'h0003);

    // R7: selector 0 ignores slice 0 (all zeros)
    v = '{2'd0, 3'd7, 1'b0, 2'd0, 3'd0, A1, B1};
    run_one(v);
    check("R7 sel0 unmasked", mask_o, 16'hFFFF);
    v.gs = 3'd1;
    run_one(v);
    check("R7 sel1", mask_o, 16'hAAAA);
    // R3 with governing all ones: only 2 qword bits
    v.gs = 3'd5; v.es = 2'd3;
    run_one(v);
    check("R3 qword upper zero", mask_o, 16'h0003);
    v.es = 2'd2;
    run_one(v);
    check("R3 dword upper zero", mask_o, 16'h000F);

    // R2: hold while valid_i low, inputs changing
    held = mask_o;
    @(negedge clk_i);
    drive('{2'd2, 3'd0, 1'b0, 2'd0, 3'd0, A3, A3});
    @(negedge clk_i);
    check("R2 valid low", MW'(valid_o), '0);
    check("R2 hold", mask_o, held);

    // R2: back-to-back valids with mode switch
    v = '{2'd1, 3'd0, 1'b0, 2'd0, 3'd0, A3, B3};
    w = '{2'd0, 3'd0, 1'b0, 2'd1, 3'd2, A1, B1};
    @(negedge clk_i);
    drive(v); valid_i = 1'b1;
    @(negedge clk_i);
    check("R2 b2b first", mask_o, model(v));
    drive(w);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2 b2b second", mask_o, model(w));
    check("R2 b2b valid", MW'(valid_o), MW'(1));

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", mask_o, '0);
    check("R1 async valid", MW'(valid_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule